// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and steers each one to either a fast interrupt output or a normal interrupt output, as a per-source class bit chooses. Software raises or masks sources through write-one-to-set and write-one-to-clear registers. It can also force any source active from a software register. Status reads show the raw request state and the enabled requests of each class.

Normal-class sources can be tied to 16 vectored slots. Each slot holds a source number, an enable bit and a handler address. The slot number sets the priority, and slot 0 ranks highest. A normal-class source that no enabled slot claims is non-vectored and is served through a default handler address. A read of the vector register returns the handler of the highest-priority pending request and records that level as in service. After that, only higher-priority slots can take over the vector. A write of any value to the vector register marks end of interrupt and releases the most urgent level in service.

The register bus is word addressed with a 6-bit address. A read returns data combinationally in the cycle the request is held. Writes, and the side effect of a vector read, take effect at the next rising clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the class, enable and software registers are all zero, so every source is normal class, and irq_o and fiq_o are low.
- R2: A class bit of 1 in the class register (address 0x03, read/write) routes that source to fiq_o. A class bit of 0 routes it to irq_o.
- R3: Writing to address 0x04 sets the enable bits that are 1 in the write data, and a read of 0x04 returns the enable bits. Writing to 0x05 clears the enable bits that are 1 in the write data. Bits written as 0 change nothing at either address.
- R4: Writing to 0x06 sets software-forced bits, and writing to 0x07 clears them. The raw status at 0x02 is the OR of the request lines and the software-forced bits, taken before enable masking.
- R5: The normal status at 0x00 equals raw AND enable AND NOT class. The fast status at 0x01 equals raw AND enable AND class.
- R6: Slot k has a handler address at 0x20+k and a control word at 0x30+k. In the control word, bits [4:0] pick the source and bit 5 enables the slot. A read of the vector register (0x0C) returns the handler address of the lowest-numbered enabled slot whose source is in the normal status.
- R7: When an enabled normal source is not claimed by any enabled slot, and no level is in service, a vector read returns the default address (0x0D, read/write) and records the non-vectored level, which ranks below all slots.
- R8: After a vector read records slot k as in service, later vector reads return only slots numbered below k. When no such slot is pending, the read returns the default address and records nothing.
- R9: A write of any value to 0x0C releases the most urgent level in service. After that, lower-priority pending requests can be returned again.
- R10: irq_o is the OR of the normal status and fiq_o is the OR of the fast status. Both follow the request lines in the same cycle.
- R11: A bus cycle with bus_req_i low changes no register, even when bus_we_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 32 | Level-sensitive interrupt request lines |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions take for granted that the bus carries at most one access per cycle. A read and an end-of-interrupt write never coincide, and control words only point at existing sources. The end-of-interrupt property also assumes that software never writes end of interrupt when no level is in service. The directed stimulus follows these rules: it drives one request per clock, starting at the falling edge, and pairs every recorded vector read with exactly one end-of-interrupt write. The request lines change only between accesses, so each vector read sees settled status.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned AW = 6;

  localparam logic [AW-1:0] A_IRQ_STAT  = 6'h00;
  localparam logic [AW-1:0] A_FIQ_STAT  = 6'h01;
  localparam logic [AW-1:0] A_RAW       = 6'h02;
  localparam logic [AW-1:0] A_CLASS     = 6'h03;
  localparam logic [AW-1:0] A_EN_SET    = 6'h04;
  localparam logic [AW-1:0] A_EN_CLR    = 6'h05;
  localparam logic [AW-1:0] A_SOFT_SET  = 6'h06;
  localparam logic [AW-1:0] A_SOFT_CLR  = 6'h07;
  localparam logic [AW-1:0] A_VECT      = 6'h0C;
  localparam logic [AW-1:0] A_DEF_ADDR  = 6'h0D;
  // slot tables: upper two address bits select the table, low bits the slot
  localparam logic [1:0]    T_SLOT_ADDR = 2'b10;
  localparam logic [1:0]    T_SLOT_CTRL = 2'b11;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_svc_stack.sv
module vic_svc_stack #(
  parameter int unsigned LEVELS = 17,
  localparam int unsigned LW = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LW-1:0]     push_lvl_i,
  input  logic              pop_i,
  output logic [LEVELS-1:0] mask_o,
  output logic              top_found_o,
  output logic [LW-1:0]     top_lvl_o
);
  logic [LEVELS-1:0] mask_q;

  vic_prio_pick #(.N(LEVELS)) u_top (
    .req_i   (mask_q),
    .found_o (top_found_o),
    .idx_o   (top_lvl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (push_i) begin
      mask_q[push_lvl_i] <= 1'b1;
    end else if (pop_i && top_found_o) begin
      mask_q[top_lvl_o] <= 1'b0;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32,
  localparam int unsigned SRC_W  = $clog2(N_SRC),
  localparam int unsigned SLOT_W = $clog2(N_SLOT),
  localparam int unsigned LVL_N  = N_SLOT + 1,
  localparam int unsigned LVL_W  = $clog2(LVL_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       irq_lines_i,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [vic_pkg::AW-1:0] bus_addr_i,
  input  logic [DW-1:0]          bus_wdata_i,
  output logic [DW-1:0]          bus_rdata_o,
  output logic                   irq_o,
  output logic                   fiq_o
);
  import vic_pkg::*;

  logic [N_SRC-1:0] sel_q, en_q, soft_q;
  logic [DW-1:0]    def_addr_q;
  logic [DW-1:0]    slot_addr_q [N_SLOT];
  logic [SRC_W:0]   slot_ctrl_q [N_SLOT];

  logic [N_SRC-1:0] raw, irq_stat, fiq_stat, claimed;
  logic [N_SLOT-1:0] slot_hit, vec_req;
  logic              vec_found, nv_pend, def_ok;
  logic [SLOT_W-1:0] vec_idx;
  logic [LVL_N-1:0]  svc_mask;
  logic              svc_found;
  logic [LVL_W-1:0]  svc_lvl;
  logic              wr, rd, vect_rd, eoi, push;
  logic [LVL_W-1:0]  push_lvl;
  logic [DW-1:0]     vect_value;
  logic              slot_tbl_ok;
  logic [SLOT_W-1:0] slot_sel;

  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  assign raw      = irq_lines_i | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & en_q & sel_q;
  assign irq_o    = |irq_stat;
  assign fiq_o    = |fiq_stat;

  // per-slot match and priority window
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    assign slot_hit[s] = slot_ctrl_q[s][SRC_W] && irq_stat[slot_ctrl_q[s][SRC_W-1:0]];
    assign vec_req[s]  = slot_hit[s] && (!svc_found || (int'(svc_lvl) > s));
  end

  always_comb begin
    claimed = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (slot_ctrl_q[s][SRC_W]) claimed[slot_ctrl_q[s][SRC_W-1:0]] = 1'b1;
    end
  end

  assign nv_pend = |(irq_stat & ~claimed);
  assign def_ok  = nv_pend && !svc_found;

  vic_prio_pick #(.N(N_SLOT)) u_pick (
    .req_i   (vec_req),
    .found_o (vec_found),
    .idx_o   (vec_idx)
  );

  assign vect_value = vec_found ? slot_addr_q[vec_idx] : def_addr_q;
  assign vect_rd    = rd && (bus_addr_i == A_VECT);
  assign eoi        = wr && (bus_addr_i == A_VECT);
  assign push       = vect_rd && (vec_found || def_ok);
  assign push_lvl   = vec_found ? LVL_W'(vec_idx) : LVL_W'(N_SLOT);

  vic_svc_stack #(.LEVELS(LVL_N)) u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_lvl_i  (push_lvl),
    .pop_i       (eoi),
    .mask_o      (svc_mask),
    .top_found_o (svc_found),
    .top_lvl_o   (svc_lvl)
  );

  assign slot_sel    = bus_addr_i[SLOT_W-1:0];
  assign slot_tbl_ok = int'(bus_addr_i[3:0]) < N_SLOT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      en_q       <= '0;
      soft_q     <= '0;
      def_addr_q <= '0;
      for (int s = 0; s < N_SLOT; s++) begin
        slot_addr_q[s] <= '0;
        slot_ctrl_q[s] <= '0;
      end
    end else if (wr) begin
      case (bus_addr_i)
        A_CLASS:    sel_q      <= bus_wdata_i[N_SRC-1:0];
        A_EN_SET:   en_q       <= en_q | bus_wdata_i[N_SRC-1:0];
        A_EN_CLR:   en_q       <= en_q & ~bus_wdata_i[N_SRC-1:0];
        A_SOFT_SET: soft_q     <= soft_q | bus_wdata_i[N_SRC-1:0];
        A_SOFT_CLR: soft_q     <= soft_q & ~bus_wdata_i[N_SRC-1:0];
        A_DEF_ADDR: def_addr_q <= bus_wdata_i;
        default: begin
          if (slot_tbl_ok && bus_addr_i[5:4] == T_SLOT_ADDR)
            slot_addr_q[slot_sel] <= bus_wdata_i;
          if (slot_tbl_ok && bus_addr_i[5:4] == T_SLOT_CTRL)
            slot_ctrl_q[slot_sel] <= bus_wdata_i[SRC_W:0];
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_IRQ_STAT: bus_rdata_o = DW'(irq_stat);
      A_FIQ_STAT: bus_rdata_o = DW'(fiq_stat);
      A_RAW:      bus_rdata_o = DW'(raw);
      A_CLASS:    bus_rdata_o = DW'(sel_q);
      A_EN_SET:   bus_rdata_o = DW'(en_q);
      A_SOFT_SET: bus_rdata_o = DW'(soft_q);
      A_VECT:     bus_rdata_o = vect_value;
      A_DEF_ADDR: bus_rdata_o = def_addr_q;
      default: begin
        if (slot_tbl_ok && bus_addr_i[5:4] == T_SLOT_ADDR)
          bus_rdata_o = slot_addr_q[slot_sel];
        if (slot_tbl_ok && bus_addr_i[5:4] == T_SLOT_CTRL)
          bus_rdata_o = DW'(slot_ctrl_q[slot_sel]);
      end
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned LVL_N = 17,
  parameter int unsigned DW    = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_req_i,
  input logic                   bus_we_i,
  input logic [vic_pkg::AW-1:0] bus_addr_i,
  input logic [DW-1:0]          bus_wdata_i,
  input logic                   irq_o,
  input logic                   fiq_o,
  input logic [N_SRC-1:0]       en_q,
  input logic [N_SRC-1:0]       soft_q,
  input logic [LVL_N-1:0]       svc_mask,
  input logic                   vec_found
);
  import vic_pkg::*;

  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == A_EN_CLR)
      |=> ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == '0));

  p_soft_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == A_SOFT_CLR)
      |=> ((soft_q & $past(bus_wdata_i[N_SRC-1:0])) == '0));

  p_quiet_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!irq_o && !fiq_o));

  p_claim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == A_VECT && vec_found)
      |=> (svc_mask != '0));

  p_eoi_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == A_VECT && svc_mask != '0)
      |=> ($countones(svc_mask) == $countones($past(svc_mask)) - 1));

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> ($stable(en_q) && $stable(soft_q)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N_SRC (N_SRC),
  .LVL_N (LVL_N),
  .DW    (DW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .en_q        (en_q),
  .soft_q      (soft_q),
  .svc_mask    (svc_mask),
  .vec_found   (vec_found)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_lines_i = '0;
  logic        bus_req_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [31:0] DEF = 32'h0000_DEF0;

  always #2 clk_i = ~clk_i;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] slot_addr(int s);
    return 32'h1000 + 32'(s) * 32'h10;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    #1 bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(posedge clk_i);
    #1 bus_req_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk_i); #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    bus_rd(6'h03, d); chk("R1 class", d, 0);
    bus_rd(6'h04, d); chk("R1 enable", d, 0);
    bus_rd(6'h06, d); chk("R1 soft", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_wr(6'h04, 32'h0F);
    bus_wr(6'h04, 32'h30);
    bus_rd(6'h04, d); chk("R3 set accumulates", d, 32'h3F);
    bus_wr(6'h05, 32'h05);
    bus_rd(6'h04, d); chk("R3 clear ones", d, 32'h3A);
    bus_wr(6'h05, 32'h0);
    bus_rd(6'h04, d); chk("R3 clear zero no effect", d, 32'h3A);
    // R11: write strobe without request
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b1; bus_addr_i = 6'h05; bus_wdata_i = '1;
    @(posedge clk_i); #1 bus_we_i = 1'b0;
    bus_rd(6'h04, d); chk("R11 idle write ignored", d, 32'h3A);
    bus_wr(6'h05, '1);
  endtask

  task automatic t_classify();
    logic [31:0] d;
    irq_lines_i = 32'h90;
    bus_wr(6'h03, 32'h10);
    settle();
    chk("R10 irq_o off before enable", 32'(irq_o), 0);
    bus_wr(6'h04, 32'h90);
    settle();
    chk("R2 fiq_o", 32'(fiq_o), 1);
    chk("R2 irq_o", 32'(irq_o), 1);
    bus_rd(6'h00, d); chk("R5 normal status", d, 32'h80);
    bus_rd(6'h01, d); chk("R5 fast status", d, 32'h10);
    irq_lines_i = 32'h10;
    #1;
    chk("R10 irq_o follows lines", 32'(irq_o), 0);
    chk("R10 fiq_o held", 32'(fiq_o), 1);
    irq_lines_i = 32'h0;
    #1;
    chk("R10 fiq_o drops", 32'(fiq_o), 0);
    bus_wr(6'h03, 32'h0);
    bus_wr(6'h05, '1);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    irq_lines_i = 32'h2;
    bus_wr(6'h06, 32'h100);
    bus_rd(6'h02, d); chk("R4 raw or", d, 32'h102);
    settle();
    chk("R4 soft not enabled", 32'(irq_o), 0);
    bus_wr(6'h04, 32'h100);
    settle();
    chk("R4 soft drives irq_o", 32'(irq_o), 1);
    bus_wr(6'h07, 32'h100);
    bus_rd(6'h02, d); chk("R4 soft cleared", d, 32'h2);
    settle();
    chk("R4 irq_o after clear", 32'(irq_o), 0);
    irq_lines_i = 32'h0;
    bus_wr(6'h05, '1);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    for (int s = 0; s < 16; s++) bus_wr(6'h20 + 6'(s), slot_addr(s));
    bus_wr(6'h0D, DEF);
    bus_wr(6'h32, 32'h25);
    bus_wr(6'h37, 32'h29);
    bus_wr(6'h30, 32'h03);
    bus_wr(6'h04, 32'h1228);
    irq_lines_i = 32'h200;
    bus_rd(6'h0C, d); chk("R6 slot 7 vector", d, slot_addr(7));
    irq_lines_i = 32'h220;
    bus_rd(6'h0C, d); chk("R8 higher slot 2 preempts", d, slot_addr(2));
    irq_lines_i = 32'h228;
    bus_rd(6'h0C, d); chk("R8 lower level blocked, default", d, DEF);
    bus_wr(6'h0C, 32'h0);
    bus_rd(6'h0C, d); chk("R9 slot 2 visible after release", d, slot_addr(2));
    bus_wr(6'h0C, 32'h0);
    bus_wr(6'h0C, 32'h0);
    irq_lines_i = 32'h8;
    bus_rd(6'h0C, d); chk("R7 unslotted source default", d, DEF);
    irq_lines_i = 32'h28;
    bus_rd(6'h0C, d); chk("R8 slot preempts default level", d, slot_addr(2));
    bus_wr(6'h0C, 32'h0);
    bus_wr(6'h0C, 32'h0);
    irq_lines_i = 32'h200;
    bus_rd(6'h0C, d); chk("R9 all released", d, slot_addr(7));
    bus_wr(6'h0C, 32'h0);
    irq_lines_i = 32'h0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    t_reset();
    t_enable();
    t_classify();
    t_soft();
    t_vector();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule